// File: doc/BRIEF.md
# Store command detector

This block sits beside a battery-free memory that keeps a working RAM and a shadow copy of it. It watches the memory's pseudo-write bus (an 11-bit address, an 8-bit data byte and four active-low strobes) for a fixed three-write unlock key. A command write is one in which the shadow-enable, chip-enable and write-enable strobes are all low together.

When the key arrives complete and in order, the block raises a one-cycle store request. It then walks every RAM location in ascending order. It issues a RAM read for each address and, one cycle later, a shadow write to the same address. A busy flag covers the whole copy. While the flag is high, further command writes are ignored.

A write with the wrong address or data drops the sequence back to the start. Ordinary RAM writes, made with the shadow-enable strobe high, leave the sequence alone. Holding output enable low during the final key write vetoes the store.

Top module: `stcmd_store_detect`

## Requirements
- R1: A command step exists only when `nv_en_n`, `chip_en_n` and `wr_en_n` are all low. It is evaluated once, when that combined strobe ends, using the address, data and `out_en_n` held in the last clock cycle the strobe was active. Values present earlier in the same strobe are not used.
- R2: The key is, in order, address 0x555 with data 0xAA, then 0x2AA with 0x55, then 0x555 with 0x33. Finishing the third step raises `store_req` for exactly one cycle, two clock edges after the strobe ends.
- R3: A command step that does not match the expected key write returns the detector to idle. If that step is itself a valid first key write, it is counted as step one.
- R4: A write with `nv_en_n` high neither advances nor resets the sequence, even when it carries a key address and data.
- R5: If `out_en_n` is low at the third step, no store starts and the detector returns to idle.
- R6: A store raises `copy_rd_en` for DEPTH consecutive cycles, with `copy_rd_addr` counting 0 to DEPTH-1. `copy_wr_en` and `copy_wr_addr` repeat the same pattern one cycle later, so exactly DEPTH shadow writes occur at ascending addresses.
- R7: `store_busy` is high from the cycle `store_req` appears until the cycle after the last shadow write. Command steps that end while busy is high are ignored, and after the copy the detector is idle.
- R8: After reset, `store_req`, `store_busy`, `copy_rd_en` and `copy_wr_en` are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Pseudo-write address |
| bus_data | input | 8 | Pseudo-write data |
| nv_en_n | input | 1 | Shadow-enable strobe, active low |
| chip_en_n | input | 1 | Chip-enable strobe, active low |
| wr_en_n | input | 1 | Write-enable strobe, active low |
| out_en_n | input | 1 | Output enable, active low; low vetoes the store |
| store_req | output | 1 | One-cycle pulse when a store starts |
| store_busy | output | 1 | High while the copy runs |
| copy_rd_en | output | 1 | RAM read strobe for the copy |
| copy_rd_addr | output | 11 | RAM read address |
| copy_wr_en | output | 1 | Shadow write strobe |
| copy_wr_addr | output | 11 | Shadow write address |

## Verification
The hardest condition to reach is a complete, correct key that arrives while a copy is already running. It must produce no second store, and the detector must then be idle once the copy ends. The stimulus reaches this by sending a second full key immediately after the first store request, well inside the 2048-cycle copy window. It then sends a key right after busy falls, which must store again.

Each command write presents a decoy address and data in its first strobe cycle and the real values only in its last. Every matching case therefore also shows that the step is sampled at the end of the strobe. The output-enable veto is driven on the third write alone. A lone third write follows it, to show the veto left the detector idle.

// File: rtl/stcmd_pkg.sv
package stcmd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/stcmd_strobe_sampler.sv
module stcmd_strobe_sampler #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              nv_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  output logic              step_v,
  output logic [ADDR_W-1:0] step_addr,
  output logic [DATA_W-1:0] step_data,
  output logic              step_oe_n
);
  logic act, act_q;

  assign act = ~nv_n & ~ce_n & ~we_n;

  // Capture follows the bus while the strobe is active and freezes when it ends
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      step_v    <= 1'b0;
      step_addr <= '0;
      step_data <= '0;
      step_oe_n <= 1'b1;
    end else begin
      act_q  <= act;
      step_v <= act_q & ~act;
      if (act) begin
        step_addr <= addr;
        step_data <= data;
        step_oe_n <= oe_n;
      end
    end
  end

  assert_step_at_release_R1: assert property (@(posedge clk) disable iff (rst)
    step_v |-> (!$past(act) && $past(act, 2)));
endmodule

// File: rtl/stcmd_seq_matcher.sv
module stcmd_seq_matcher
  import stcmd_pkg::*;
#(
  parameter int              ADDR_W = 11,
  parameter int              DATA_W = 8,
  parameter logic [ADDR_W-1:0] K1_ADDR = ADDR_W'('h555),
  parameter logic [DATA_W-1:0] K1_DATA = DATA_W'('hAA),
  parameter logic [ADDR_W-1:0] K2_ADDR = ADDR_W'('h2AA),
  parameter logic [DATA_W-1:0] K2_DATA = DATA_W'('h55),
  parameter logic [ADDR_W-1:0] K3_ADDR = ADDR_W'('h555),
  parameter logic [DATA_W-1:0] K3_DATA = DATA_W'('h33)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_v,
  input  logic [ADDR_W-1:0] step_addr,
  input  logic [DATA_W-1:0] step_data,
  input  logic              step_oe_n,
  input  logic              busy,
  output logic              start,
  output logic              store_req
);
  seq_state_e state, nxt;
  logic hit1, hit2, hit3;

  assign hit1 = (step_addr == K1_ADDR) && (step_data == K1_DATA);
  assign hit2 = (step_addr == K2_ADDR) && (step_data == K2_DATA);
  assign hit3 = (step_addr == K3_ADDR) && (step_data == K3_DATA);

  always_comb begin
    nxt   = state;
    start = 1'b0;
    if (step_v && !busy) begin
      unique case (state)
        SEQ_IDLE: nxt = hit1 ? SEQ_GOT1 : SEQ_IDLE;
        SEQ_GOT1: nxt = hit2 ? SEQ_GOT2 : (hit1 ? SEQ_GOT1 : SEQ_IDLE);
        SEQ_GOT2: begin
          if (hit3) begin
            nxt   = SEQ_IDLE;
            start = step_oe_n;
          end else begin
            nxt = hit1 ? SEQ_GOT1 : SEQ_IDLE;
          end
        end
        default: nxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      store_req <= 1'b0;
    end else begin
      state     <= nxt;
      store_req <= start;
    end
  end

  assert_req_single_R2: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);

  assert_oe_veto_R5: assert property (@(posedge clk) disable iff (rst)
    (step_v && !step_oe_n) |=> !store_req);

  assert_req_with_busy_R7: assert property (@(posedge clk) disable iff (rst)
    store_req |-> busy);
endmodule

// File: rtl/stcmd_copy_seq.sv
module stcmd_copy_seq #(
  parameter int DEPTH = 2048,
  localparam int CA_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            rd_en,
  output logic [CA_W-1:0] rd_addr,
  output logic            wr_en,
  output logic [CA_W-1:0] wr_addr
);
  localparam logic [CA_W-1:0] LAST = CA_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en   <= rd_en;
      wr_addr <= rd_addr;
      if (start) begin
        rd_en   <= 1'b1;
        rd_addr <= '0;
      end else if (rd_en) begin
        if (rd_addr == LAST) rd_en <= 1'b0;
        else                 rd_addr <= rd_addr + 1'b1;
      end
      if (start)                           busy <= 1'b1;
      else if (wr_en && (wr_addr == LAST)) busy <= 1'b0;
    end
  end

  assert_wr_follows_rd_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (wr_en && (wr_addr == $past(rd_addr))));

  assert_rd_ascends_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  assert_wr_inside_busy_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);
endmodule

// File: rtl/stcmd_store_detect.sv
module stcmd_store_detect #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048,
  localparam int CA_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              nv_en_n,
  input  logic              chip_en_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  output logic              store_req,
  output logic              store_busy,
  output logic              copy_rd_en,
  output logic [CA_W-1:0]   copy_rd_addr,
  output logic              copy_wr_en,
  output logic [CA_W-1:0]   copy_wr_addr
);
  logic              step_v, step_oe_n, start;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;

  stcmd_strobe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk(clk), .rst(rst), .addr(bus_addr), .data(bus_data),
    .nv_n(nv_en_n), .ce_n(chip_en_n), .we_n(wr_en_n), .oe_n(out_en_n),
    .step_v(step_v), .step_addr(step_addr), .step_data(step_data),
    .step_oe_n(step_oe_n)
  );

  stcmd_seq_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_matcher (
    .clk(clk), .rst(rst), .step_v(step_v), .step_addr(step_addr),
    .step_data(step_data), .step_oe_n(step_oe_n), .busy(store_busy),
    .start(start), .store_req(store_req)
  );

  stcmd_copy_seq #(.DEPTH(DEPTH)) u_copy (
    .clk(clk), .rst(rst), .start(start), .busy(store_busy),
    .rd_en(copy_rd_en), .rd_addr(copy_rd_addr),
    .wr_en(copy_wr_en), .wr_addr(copy_wr_addr)
  );
endmodule

// File: tb/stcmd_store_detect_bench.sv
module stcmd_store_detect_bench;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        nv_en_n = 1'b1, chip_en_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
  logic        store_req, store_busy, copy_rd_en, copy_wr_en;
  logic [10:0] copy_rd_addr, copy_wr_addr;

  int    n_checks = 0;
  int    n_err    = 0;
  int    expq[$];
  int    wr_cnt   = 0;
  logic  prev_busy = 1'b0;
  string cur_req  = "R8";

  always #10 clk = ~clk;

  stcmd_store_detect #(.DEPTH(DEPTH)) u_stcmd_store_detect (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .nv_en_n(nv_en_n), .chip_en_n(chip_en_n), .wr_en_n(wr_en_n),
    .out_en_n(out_en_n), .store_req(store_req), .store_busy(store_busy),
    .copy_rd_en(copy_rd_en), .copy_rd_addr(copy_rd_addr),
    .copy_wr_en(copy_wr_en), .copy_wr_addr(copy_wr_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pseudo write: decoy values in the first strobe cycle, real ones in the last (R1)
  task automatic bus_wr(input logic nv_n, input logic ce_n, input logic [10:0] a,
                        input logic [7:0] d, input logic oe_n);
    @(negedge clk);
    bus_addr = a ^ 11'h0F0; bus_data = d ^ 8'h0F;
    nv_en_n = nv_n; chip_en_n = ce_n; wr_en_n = 1'b0; out_en_n = oe_n;
    @(negedge clk);
    bus_addr = a; bus_data = d;
    @(negedge clk);
    nv_en_n = 1'b1; chip_en_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [10:0] a, input logic [7:0] d);
    bus_wr(1'b0, 1'b0, a, d, 1'b1);
  endtask

  task automatic full_key();
    cmd(11'h555, 8'hAA); cmd(11'h2AA, 8'h55); cmd(11'h555, 8'h33);
  endtask

  // Waits out any copy, then no expected store may remain pending
  task automatic settle(input string req);
    while (store_busy) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, req, "expected store missing", expq.size(), 0);
    chk(store_busy == 1'b0, req, "busy after settle", int'(store_busy), 0);
  endtask

  // Monitor: pops the scoreboard on each store and checks the copy stream
  always @(negedge clk) begin
    if (!rst) begin
      if (store_req) begin
        if (expq.size() == 0) chk(1'b0, cur_req, "unexpected store_req", 1, 0);
        else begin
          void'(expq.pop_front());
          chk(1'b1, cur_req, "store_req", 1, 1);
        end
        chk(store_busy == 1'b1, "R7", "busy with store_req", int'(store_busy), 1);
        wr_cnt = 0;
      end
      if (copy_wr_en) begin
        if (copy_wr_addr != 11'(wr_cnt))
          chk(1'b0, "R6", "shadow write address", int'(copy_wr_addr), wr_cnt);
        wr_cnt++;
      end
      if (prev_busy && !store_busy)
        chk(wr_cnt == DEPTH, "R6", "shadow writes per store", wr_cnt, DEPTH);
      prev_busy = store_busy;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk({store_req, store_busy, copy_rd_en, copy_wr_en} == 4'b0, "R8",
        "outputs in reset", int'({store_req, store_busy, copy_rd_en, copy_wr_en}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk({store_req, store_busy, copy_rd_en, copy_wr_en} == 4'b0, "R8",
        "outputs after reset", int'({store_req, store_busy, copy_rd_en, copy_wr_en}), 0);

    // R2/R6: correct key; exact latency of store_req
    cur_req = "R2";
    cmd(11'h555, 8'hAA); cmd(11'h2AA, 8'h55);
    expq.push_back(1);
    @(negedge clk);
    bus_addr = 11'h555; bus_data = 8'h33;
    nv_en_n = 1'b0; chip_en_n = 1'b0; wr_en_n = 1'b0;
    @(negedge clk);
    nv_en_n = 1'b1; chip_en_n = 1'b1; wr_en_n = 1'b1;
    @(negedge clk);
    chk(store_req == 1'b0, "R2", "store_req one edge after release", int'(store_req), 0);
    @(negedge clk);
    chk(store_req == 1'b1, "R2", "store_req two edges after release", int'(store_req), 1);
    chk(copy_rd_en == 1'b1 && copy_rd_addr == 11'd0, "R6", "first read address",
        int'(copy_rd_addr), 0);
    settle("R2");

    // R1: chip enable high makes step one not a command step
    cur_req = "R1";
    bus_wr(1'b0, 1'b1, 11'h555, 8'hAA, 1'b1);
    cmd(11'h2AA, 8'h55); cmd(11'h555, 8'h33);
    settle("R1");

    // R3: each single wrong step
    cur_req = "R3";
    cmd(11'h555, 8'hAB); cmd(11'h2AA, 8'h55); cmd(11'h555, 8'h33);
    settle("R3");
    cmd(11'h555, 8'hAA); cmd(11'h2AB, 8'h55); cmd(11'h555, 8'h33);
    settle("R3");
    cmd(11'h555, 8'hAA); cmd(11'h2AA, 8'h55); cmd(11'h555, 8'h34);
    settle("R3");
    // R3: wrong step that is a valid step one restarts at step one
    cmd(11'h555, 8'hAA); cmd(11'h555, 8'hAA);
    expq.push_back(1);
    cmd(11'h2AA, 8'h55); cmd(11'h555, 8'h33);
    settle("R3");

    // R4: RAM writes between steps change nothing
    cur_req = "R4";
    cmd(11'h555, 8'hAA);
    bus_wr(1'b1, 1'b0, 11'h123, 8'h00, 1'b1);
    cmd(11'h2AA, 8'h55);
    bus_wr(1'b1, 1'b0, 11'h555, 8'hAA, 1'b1);
    expq.push_back(1);
    cmd(11'h555, 8'h33);
    settle("R4");
    // R4: a RAM write carrying step one does not count as step one
    bus_wr(1'b1, 1'b0, 11'h555, 8'hAA, 1'b1);
    cmd(11'h2AA, 8'h55); cmd(11'h555, 8'h33);
    settle("R4");

    // R5: output enable low on step three vetoes, then detector is idle
    cur_req = "R5";
    cmd(11'h555, 8'hAA); cmd(11'h2AA, 8'h55);
    bus_wr(1'b0, 1'b0, 11'h555, 8'h33, 1'b0);
    cmd(11'h555, 8'h33);
    settle("R5");

    // R7: a second key during busy is ignored; then back-to-back keys
    cur_req = "R7";
    expq.push_back(1);
    full_key();
    chk(store_busy == 1'b1, "R7", "busy during copy", int'(store_busy), 1);
    full_key();
    settle("R7");
    expq.push_back(1);
    full_key();
    while (store_busy) @(negedge clk);
    expq.push_back(1);
    full_key();
    settle("R7");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule